// File: doc/BRIEF.md
# Seconds/Minutes/Hours Update and Alarm Sequencer

This block keeps the time of day as seconds, minutes and hours in two copies: an internal copy that always advances, and a user copy that software reads and writes through a small register port. A prescaler counts enable pulses at the 32.768 kHz rate. At each one-second boundary it advances the internal copy. When the freeze control is clear, it transfers the new time to the user copy. It also compares the advanced time against three alarm bytes, and it emits an update-ended pulse and, on a match, an alarm pulse.

Software can see that a transfer is coming. A status bit rises a fixed number of enable ticks before each boundary and stays high until the boundary. Raising the freeze control holds the user copy so that software can write a new time, while the internal time keeps running. Dropping the freeze control copies the written time into the internal copy. All time and alarm bytes share one data mode, BCD or binary. The hours byte uses either 24-hour coding or 12-hour coding with a PM flag.

Top module: `rtc_tick_seq`

## Requirements
- R1: After reset, the time and alarm registers (addresses 0 to 5) read 0x00. The control register (address 6) reads 0x01. The status register (address 7) reads 0x00. Both event outputs are low.
- R2: Every TICKS_PER_SEC enable ticks, the internal time advances by one second. The register `upd_evt` is high for exactly one clock after that boundary. In that same clock, the user copy at addresses 0 (seconds), 1 (minutes) and 2 (hours) already shows the new time when freeze is clear.
- R3: Status bit 7 reads 1 during the last UIP_TICKS ticks before each boundary and reads 0 at all other times. Status bits 6:0 read 0. Writes to address 7 have no effect.
- R4: While control bit 7 (freeze) is 1, the user time registers keep whatever was last written to them. The internal time still advances, and the alarm comparison still runs on it. Status bit 7 stays 0, and `upd_evt` still pulses every second.
- R5: A control write that changes freeze from 1 to 0 loads the user time into the internal copy. The following boundary then shows the written time plus one second.
- R6: A control write that changes freeze from 0 to 1 clears the update-interrupt-enable bit (control bit 3), whatever value is written to that bit. Otherwise bit 3 stores the written value.
- R7: In BCD mode (control bit 1 = 0), seconds and minutes wrap from 0x59 to 0x00 and carry. In 24-hour mode (control bit 0 = 1), 23:59:59 becomes 00:00:00.
- R8: In binary mode (control bit 1 = 1), the same rollovers use binary codes. For example, 0x17:0x3B:0x3B becomes 0x00:0x00:0x00.
- R9: In 12-hour mode (control bit 0 = 0), hour bit 7 is the PM flag. Hour 11 is followed by 12 with PM inverted, and hour 12 is followed by 1 with PM unchanged. For example, 0x11:59:59 becomes 0x92:00:00, and 0x92:59:59 becomes 0x81:00:00.
- R10: `alarm_evt` pulses together with `upd_evt` when each of the three alarm bytes (addresses 3 seconds, 4 minutes, 5 hours) equals the corresponding byte of the advanced time. `alarm_evt` never pulses without `upd_evt`.
- R11: An alarm byte whose two top bits are both 1 (codes 0xC0 to 0xFF) matches any value. With all three bytes set this way, the alarm fires every second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Enable pulse at the 32.768 kHz rate |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0-2 time, 3-5 alarm, 6 control, 7 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| upd_evt | output | 1 | One-clock pulse after each one-second update |
| alarm_evt | output | 1 | One-clock pulse when the updated time matches the alarm |

## Verification
If the prescaler count drifts, the spacing between `upd_evt` pulses and the position of the status bit inside each second both move. The bench sees this within one second. If the increment logic carries wrongly, the user registers show the wrong value at the first boundary that exercises that carry. The bench sets each rollover up one second before it happens. If the freeze, reload or alarm state is wrong, the next update pulse is already affected: the user registers change while frozen, a reloaded time fails to appear, or an alarm pulse is missing or extra.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

    // index 0 = seconds, 1 = minutes, 2 = hours
    typedef logic [2:0][7:0] hms_t;

    // decode a stored byte to a plain number
    function automatic logic [6:0] code_to_num(input logic [7:0] v, input logic bin);
        logic [6:0] t;
        if (bin) begin
            t = v[6:0];
        end else begin
            t = 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
        end
        return t;
    endfunction

    // encode a plain number in the selected data mode
    function automatic logic [7:0] num_to_code(input logic [6:0] n, input logic bin);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = n / 7'd10;
        ones = n % 7'd10;
        if (bin) begin
            return {1'b0, n};
        end
        return {tens[3:0], ones[3:0]};
    endfunction

endpackage

// File: rtl/rtc_sec_prescale.sv
module rtc_sec_prescale #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    output logic sec_strobe,
    output logic uip
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] WARN = CW'(TICKS_PER_SEC - UIP_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ps_t;

    ps_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (tick) begin
            ps_d.cnt = (ps_q.cnt == LAST) ? '0 : ps_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign sec_strobe = tick && (ps_q.cnt == LAST);
    assign uip        = !freeze && (ps_q.cnt >= WARN);

    // R2: boundaries are never back to back
    a_r2_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        sec_strobe |=> !sec_strobe);

    // R3: warning is always up when an unfrozen boundary arrives
    a_r3_uip_before_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_strobe && !freeze) |-> uip);

endmodule

// File: rtl/rtc_time_adv.sv
module rtc_time_adv
    import rtc_seq_pkg::*;
(
    input  hms_t cur,
    input  logic dm_bin,
    input  logic h24,
    output hms_t nxt
);
    logic [6:0] s_n, m_n, h_n;
    logic       s_wrap, m_wrap, pm;

    always_comb begin
        s_n    = code_to_num(cur[0], dm_bin);
        m_n    = code_to_num(cur[1], dm_bin);
        pm     = cur[2][7];
        h_n    = h24 ? code_to_num(cur[2], dm_bin)
                     : code_to_num({1'b0, cur[2][6:0]}, dm_bin);
        s_wrap = (s_n >= 7'd59);
        m_wrap = s_wrap && (m_n >= 7'd59);

        nxt[0] = s_wrap ? num_to_code(7'd0, dm_bin) : num_to_code(s_n + 7'd1, dm_bin);
        if (!s_wrap)     nxt[1] = cur[1];
        else if (m_wrap) nxt[1] = num_to_code(7'd0, dm_bin);
        else             nxt[1] = num_to_code(m_n + 7'd1, dm_bin);

        nxt[2] = cur[2];
        if (m_wrap) begin
            if (h24) begin
                nxt[2] = (h_n >= 7'd23) ? num_to_code(7'd0, dm_bin)
                                        : num_to_code(h_n + 7'd1, dm_bin);
            end else if (h_n == 7'd11) begin
                nxt[2] = {~pm, num_to_code(7'd12, dm_bin)[6:0]};
            end else if (h_n >= 7'd12) begin
                nxt[2] = {pm, num_to_code(7'd1, dm_bin)[6:0]};
            end else begin
                nxt[2] = {pm, num_to_code(h_n + 7'd1, dm_bin)[6:0]};
            end
        end
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_seq_pkg::*;
(
    input  hms_t cur,
    input  hms_t alm,
    output logic hit
);
    logic [2:0] field_ok;

    for (genvar i = 0; i < 3; i++) begin : g_field
        assign field_ok[i] = (alm[i][7:6] == 2'b11) || (alm[i] == cur[i]);
    end

    assign hit = &field_ok;
endmodule

// File: rtl/rtc_tick_seq.sv
module rtc_tick_seq
    import rtc_seq_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       we,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       upd_evt,
    output logic       alarm_evt
);
    typedef struct packed {
        hms_t usr;
        hms_t inn;
        hms_t alm;
        logic set;
        logic uie;
        logic dm;
        logic h24;
        logic upd;
        logic alm_evt;
    } seq_st_t;

    localparam seq_st_t RST_ST = '{usr: '0, inn: '0, alm: '0, set: 1'b0, uie: 1'b0,
                                   dm: 1'b0, h24: 1'b1, upd: 1'b0, alm_evt: 1'b0};

    seq_st_t q, d;
    logic    sec_strobe, uip, hit;
    hms_t    adv;

    rtc_sec_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(q.set),
        .sec_strobe(sec_strobe), .uip(uip)
    );

    rtc_time_adv u_adv (.cur(q.inn), .dm_bin(q.dm), .h24(q.h24), .nxt(adv));

    rtc_alarm_cmp u_cmp (.cur(adv), .alm(q.alm), .hit(hit));

    always_comb begin
        d         = q;
        d.upd     = 1'b0;
        d.alm_evt = 1'b0;
        if (sec_strobe) begin
            d.inn     = adv;
            d.upd     = 1'b1;
            d.alm_evt = hit;
            if (!q.set) d.usr = adv;
        end
        if (we) begin
            case (addr)
                3'd0: d.usr[0] = wdata;
                3'd1: d.usr[1] = wdata;
                3'd2: d.usr[2] = wdata;
                3'd3: d.alm[0] = wdata;
                3'd4: d.alm[1] = wdata;
                3'd5: d.alm[2] = wdata;
                3'd6: begin
                    d.set = wdata[7];
                    d.uie = wdata[3] && !(wdata[7] && !q.set);
                    d.dm  = wdata[1];
                    d.h24 = wdata[0];
                    if (q.set && !wdata[7]) d.inn = d.usr;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_ST;
        else        q <= d;
    end

    always_comb begin
        case (addr)
            3'd0:    rdata = q.usr[0];
            3'd1:    rdata = q.usr[1];
            3'd2:    rdata = q.usr[2];
            3'd3:    rdata = q.alm[0];
            3'd4:    rdata = q.alm[1];
            3'd5:    rdata = q.alm[2];
            3'd6:    rdata = {q.set, 3'b000, q.uie, 1'b0, q.dm, q.h24};
            default: rdata = {uip, 7'b0};
        endcase
    end

    assign upd_evt   = q.upd;
    assign alarm_evt = q.alm_evt;

    // R4: frozen user copy only changes through the write port
    a_r4_user_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (q.set && !(we && addr <= 3'd2)) |=> $stable(q.usr));

    // R3: warning bit held low while frozen
    a_r3_uip_low_in_set: assert property (@(posedge clk) disable iff (!rst_n)
        q.set |-> !uip);

    // R10: alarm only alongside an update
    a_r10_alarm_with_update: assert property (@(posedge clk) disable iff (!rst_n)
        q.alm_evt |-> q.upd);

    // R6: entering freeze leaves the update enable cleared
    a_r6_set_clears_uie: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.set) |-> !q.uie);

    // R2: every update pulse follows a prescaler boundary
    a_r2_upd_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        q.upd |-> $past(sec_strobe));

endmodule

// File: tb/sim_rtc_tick_seq.sv
`timescale 1ns/1ps
module sim_rtc_tick_seq;
    localparam int TPS = 32;
    localparam int UIPT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       we = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       upd_evt, alarm_evt;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit exp_alm_q[$];

    // model state
    logic [7:0] m_usr [3];
    logic [7:0] m_inn [3];
    logic [7:0] m_alm [3];
    bit m_set = 0, m_uie = 0, m_dm = 0, m_h24 = 1;

    rtc_tick_seq #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .upd_evt(upd_evt), .alarm_evt(alarm_evt)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // monitor: pops the expected alarm outcome at each update pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (upd_evt) begin
                if (exp_alm_q.size() > 0) begin
                    automatic bit e = exp_alm_q.pop_front();
                    chk(alarm_evt == e, "R10/R11 alarm pulse", int'(alarm_evt), int'(e));
                end
            end else if (alarm_evt) begin
                chk(1'b0, "R10 alarm without update", 1, 0);
            end
        end
    end

    function automatic int v2n(input logic [7:0] v, input bit bin);
        if (bin) return int'(v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] n2v(input int n, input bit bin);
        if (bin) return 8'(n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic bit fld_match(input logic [7:0] a, input logic [7:0] t);
        return (a[7:6] == 2'b11) || (a == t);
    endfunction

    task automatic model_adv(output bit alm);
        int s, m, h;
        bit pm;
        s  = v2n(m_inn[0], m_dm);
        m  = v2n(m_inn[1], m_dm);
        pm = m_inn[2][7];
        h  = m_h24 ? v2n(m_inn[2], m_dm) : v2n({1'b0, m_inn[2][6:0]}, m_dm);
        if (s >= 59) begin
            s = 0;
            if (m >= 59) begin
                m = 0;
                if (m_h24) h = (h >= 23) ? 0 : h + 1;
                else if (h == 11) begin h = 12; pm = !pm; end
                else if (h >= 12) h = 1;
                else h = h + 1;
            end else m = m + 1;
        end else s = s + 1;
        m_inn[0] = n2v(s, m_dm);
        m_inn[1] = n2v(m, m_dm);
        m_inn[2] = m_h24 ? n2v(h, m_dm) : {pm, n2v(h, m_dm)[6:0]};
        alm = fld_match(m_alm[0], m_inn[0]) && fld_match(m_alm[1], m_inn[1])
              && fld_match(m_alm[2], m_inn[2]);
        if (!m_set) for (int i = 0; i < 3; i++) m_usr[i] = m_inn[i];
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        we = 1'b0;
        case (a)
            3'd0, 3'd1, 3'd2: m_usr[a] = v;
            3'd3, 3'd4, 3'd5: m_alm[a - 3'd3] = v;
            3'd6: begin
                m_uie = v[3] && !(v[7] && !m_set);
                if (m_set && !v[7]) for (int i = 0; i < 3; i++) m_inn[i] = m_usr[i];
                m_set = v[7]; m_dm = v[1]; m_h24 = v[0];
            end
            default: ;
        endcase
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        chk(rdata === exp, req, int'(rdata), int'(exp));
    endtask

    task automatic chk_user(input string req);
        for (int i = 0; i < 3; i++) rd_chk(3'(i), m_usr[i], req);
    endtask

    task automatic wait_sec();
        bit a;
        model_adv(a);
        exp_alm_q.push_back(a);
        do @(negedge clk); while (!upd_evt);
    endtask

    initial begin
        m_usr = '{8'h00, 8'h00, 8'h00};
        m_inn = '{8'h00, 8'h00, 8'h00};
        m_alm = '{8'h00, 8'h00, 8'h00};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 6; i++) rd_chk(3'(i), 8'h00, "R1 time/alarm reset");
        rd_chk(3'd6, 8'h01, "R1 control reset");
        rd_chk(3'd7, 8'h00, "R1 status reset");
        chk(!upd_evt && !alarm_evt, "R1 events idle", int'({upd_evt, alarm_evt}), 0);

        wr(3'd5, 8'h3F);
        wait_sec(); chk_user("R2 first second");
        wait_sec(); chk_user("R2 second second");

        // R3 warning window inside one second
        repeat (23) @(negedge clk);
        rd_chk(3'd7, 8'h00, "R3 status low before window");
        @(negedge clk);
        rd_chk(3'd7, 8'h80, "R3 status high in window");
        wr(3'd7, 8'h00);
        rd_chk(3'd7, 8'h80, "R3 status write ignored");
        repeat (5) @(negedge clk);
        rd_chk(3'd7, 8'h80, "R3 status high at last tick");
        wait_sec(); chk_user("R2 third second");
        rd_chk(3'd7, 8'h00, "R3 status low after edge");

        // R6 update enable
        wr(3'd6, 8'h09);
        rd_chk(3'd6, 8'h09, "R6 enable stored");
        wr(3'd6, 8'h89);
        rd_chk(3'd6, {m_set, 3'b0, m_uie, 1'b0, m_dm, m_h24}, "R6 freeze clears enable");

        // R4 frozen user copy, R11 all don't-care alarms
        wr(3'd3, 8'hC0); wr(3'd4, 8'hFF); wr(3'd5, 8'hC3);
        wait_sec(); chk_user("R4 frozen");
        repeat (26) @(negedge clk);
        rd_chk(3'd7, 8'h00, "R4 status low while frozen");
        wait_sec(); chk_user("R4 still frozen R11");

        // R5 reload, R10 exact alarm, R7 BCD rollover
        wr(3'd0, 8'h58); wr(3'd1, 8'h59); wr(3'd2, 8'h23);
        wr(3'd3, 8'h59); wr(3'd4, 8'h59); wr(3'd5, 8'h23);
        wr(3'd6, 8'h01);
        chk_user("R5 written time visible");
        wait_sec(); chk_user("R5 R7 R10 reload then 23:59:59");
        wait_sec(); chk_user("R7 BCD midnight");

        // R8 binary mode
        wr(3'd6, 8'h83);
        wr(3'd0, 8'h3A); wr(3'd1, 8'h3B); wr(3'd2, 8'h17);
        wr(3'd3, 8'h3B); wr(3'd4, 8'hC0); wr(3'd5, 8'hC0);
        wr(3'd6, 8'h03);
        wait_sec(); chk_user("R8 binary 23:59:59");
        wait_sec(); chk_user("R8 binary midnight");

        // R9 12-hour mode
        wr(3'd6, 8'h80);
        wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h11);
        wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h3F);
        wr(3'd6, 8'h00);
        wait_sec(); chk_user("R9 11 AM to 12 PM");
        rd_chk(3'd2, 8'h92, "R9 hour code 12 PM");
        wr(3'd6, 8'h80);
        wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h92);
        wr(3'd6, 8'h00);
        wait_sec(); chk_user("R9 12 PM to 1 PM");
        rd_chk(3'd2, 8'h81, "R9 hour code 1 PM");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule